// File: doc/BRIEF.md
# Host-to-I/O Address Window Forwarder

This block sits between a 40-bit host bus and a 32-bit downstream I/O bus. It decides, for each host request, whether the request belongs to the I/O side, and it produces the downstream address. Two programmable address windows, each held as a low/high register pair, are compared against every request in parallel. A control register holds a two-bit forwarding mode that selects one of three behaviours for a matching request: block it, pass it through, or pass it into the broadcast region of the downstream space.

Bit positions in this brief use the usual little-endian numbering (bit 0 is the least significant). A host address falls in a window only when three conditions all hold. Its top byte must be all ones. Its next nibble must match a segment code in the window's low register. Its next twelve bits must lie in the half-open span given by the low and high registers. The 16 least significant host bits take no part in the compare. The downstream address is a fixed re-slicing of the host address. In broadcast mode its high-order bits are also forced to ones.

Software-side writes arrive on a simple write port. A request that follows a write in a later cycle always sees the new value. The result for each request is registered and appears one cycle later.

Top module: `io_window_fwd`

## Requirements
- R1: A request can hit a window only when req_addr[39:32] is 8'hFF.
- R2: A request hits window k only when req_addr[31:28] equals bits [15:12] of window k's low register.
- R3: A request hits window k only when req_addr[27:16] is at least low[11:0] and strictly below high[11:0] of window k. req_addr[15:0] never affects the result. A window whose low[11:0] is at least its high[11:0] matches nothing.
- R4: The two windows are checked independently. out_hit is 1 when either hits. out_win gives the hitting window, and window 0 wins when both hit. out_win is 0 when nothing hits.
- R5: A forwarded request has out_addr = {4'hF, req_addr[27:2], 2'b00}, before any broadcast forcing.
- R6: The mode is control register bits [8:7]. Value 1 forwards every hit. Values 0 and 2 forward nothing (out_fwd stays 0, out_hit still reports the hit). The other control bits have no effect.
- R7: Mode 3 forwards a hit only when req_short_wr is 1, and it then forces out_addr[31:18] to all ones. In every other case out_addr is 0 when out_fwd is 0.
- R8: The write select codes are: 0 for the control register, 1 for low0, 2 for high0, 3 for low1, 4 for high1. A request presented in the same cycle as a write is judged against the old contents. A request in any later cycle is judged against the new contents.
- R9: The outputs are registered. out_valid and the results appear on the clock edge after req_valid is sampled high. out_valid is 0 in cycles with no request. Reset clears all outputs and registers, which leaves both windows empty and the mode at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (R8 encoding) |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Host request present |
| req_addr | input | 40 | Host request address |
| req_short_wr | input | 1 | Request is a short write |
| out_valid | output | 1 | Result valid, one cycle after a request |
| out_fwd | output | 1 | Request is forwarded downstream |
| out_hit | output | 1 | Some window matched |
| out_win | output | 1 | Index of the matching window |
| out_addr | output | 32 | Downstream address, 0 when not forwarded |

## Verification
The embedded properties check several rules on every cycle: the result follows a request by one cycle, a hit implies the all-ones prefix, and the downstream frame bits are fixed. They also check that blocking modes never forward, that broadcast forwarding implies a short write with the forced top bits, and that window 0 takes priority. The exact segment and span boundaries cannot be checked by a property, and neither can the insensitivity to the low host bits or the read-old/see-new timing of register writes. Those are shown only by the bench. It sweeps the span value across both windows' edges, in every mode, with and without a segment match, a valid prefix and a short write, and it programs empty and overlapping windows.

// File: rtl/io_window_pkg.sv
package io_window_pkg;

  // Forwarding behaviour selected by the control register mode field.
  typedef enum logic [1:0] {
    FWD_BLOCK   = 2'd0,
    FWD_PASS    = 2'd1,
    FWD_RSVD    = 2'd2,
    FWD_BCAST   = 2'd3
  } fwd_mode_e;

  // Register select: 0 is control, then low/high per window.
  localparam int unsigned SEL_CTRL = 0;

  function automatic int unsigned sel_low(input int unsigned win);
    return 1 + 2 * win;
  endfunction

  function automatic int unsigned sel_high(input int unsigned win);
    return 2 + 2 * win;
  endfunction

endpackage

// File: rtl/window_regs.sv
module window_regs
  import io_window_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned MODE_LSB = 7,
  localparam int unsigned SEL_W   = $clog2(2 * NUM_WIN + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_WIN-1:0][DATA_W-1:0] win_lo,
  output logic [NUM_WIN-1:0][DATA_W-1:0] win_hi,
  output fwd_mode_e                      mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= FWD_BLOCK;
    end else if (wr_en && wr_sel == SEL_W'(SEL_CTRL)) begin
      mode <= fwd_mode_e'(wr_data[MODE_LSB +: 2]);
    end
  end

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win_lo[k] <= '0;
        win_hi[k] <= '0;
      end else if (wr_en) begin
        if (wr_sel == SEL_W'(sel_low(k)))  win_lo[k] <= wr_data;
        if (wr_sel == SEL_W'(sel_high(k))) win_hi[k] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/window_match.sv
module window_match #(
  parameter int unsigned HADDR_W = 40,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PFX_W   = 8,
  parameter int unsigned SEG_W   = 4,
  parameter int unsigned RNG_W   = 12,
  localparam int unsigned SEG_TOP = HADDR_W - PFX_W - 1,
  localparam int unsigned RNG_TOP = SEG_TOP - SEG_W
) (
  input  logic [HADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]  lo,
  input  logic [DATA_W-1:0]  hi,
  output logic               hit
);

  logic             pfx_ok;
  logic             seg_ok;
  logic             rng_ok;
  logic [RNG_W-1:0] a_rng;
  logic [RNG_W-1:0] lo_rng;
  logic [RNG_W-1:0] hi_rng;

  assign a_rng  = addr[RNG_TOP -: RNG_W];
  assign lo_rng = lo[RNG_W-1:0];
  assign hi_rng = hi[RNG_W-1:0];

  assign pfx_ok = &addr[HADDR_W-1 -: PFX_W];
  assign seg_ok = addr[SEG_TOP -: SEG_W] == lo[RNG_W +: SEG_W];
  assign rng_ok = (a_rng >= lo_rng) && (a_rng < hi_rng);
  assign hit    = pfx_ok && seg_ok && rng_ok;

  // R3: a matching window always has a non-empty span
  always_comb begin
    if (hit) begin
      nonempty_span_chk: assert (lo_rng < hi_rng);
    end
  end

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int unsigned HADDR_W = 40,
  parameter int unsigned DADDR_W = 32,
  parameter int unsigned PFX_W   = 8,
  parameter int unsigned SEG_W   = 4,
  parameter int unsigned TOP_W   = 4,
  parameter int unsigned BCAST_W = 14,
  localparam int unsigned LOW_W  = 2,
  localparam int unsigned MID_W  = DADDR_W - TOP_W - LOW_W,
  localparam int unsigned SRC_TOP = HADDR_W - PFX_W - SEG_W - 1
) (
  input  logic [HADDR_W-1:0] addr,
  input  logic               bcast,
  output logic [DADDR_W-1:0] daddr
);

  logic [DADDR_W-1:0] base;

  assign base = {{TOP_W{1'b1}}, addr[SRC_TOP -: MID_W], {LOW_W{1'b0}}};

  always_comb begin
    daddr = base;
    if (bcast) daddr[DADDR_W-1 -: BCAST_W] = '1;
  end

endmodule

// File: rtl/io_window_fwd.sv
module io_window_fwd
  import io_window_pkg::*;
#(
  parameter int unsigned HADDR_W  = 40,
  parameter int unsigned DADDR_W  = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned PFX_W    = 8,
  parameter int unsigned SEG_W    = 4,
  parameter int unsigned RNG_W    = 12,
  parameter int unsigned TOP_W    = 4,
  parameter int unsigned BCAST_W  = 14,
  parameter int unsigned MODE_LSB = 7,
  localparam int unsigned SEL_W   = $clog2(2 * NUM_WIN + 1),
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               req_valid,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic               req_short_wr,
  output logic               out_valid,
  output logic               out_fwd,
  output logic               out_hit,
  output logic [IDX_W-1:0]   out_win,
  output logic [DADDR_W-1:0] out_addr
);

  logic [NUM_WIN-1:0][DATA_W-1:0] win_lo;
  logic [NUM_WIN-1:0][DATA_W-1:0] win_hi;
  fwd_mode_e                      mode;
  logic [NUM_WIN-1:0]             w_hit;
  logic                           any_hit;
  logic [IDX_W-1:0]               sel_idx;
  logic                           bcast;
  logic                           pass;
  logic [DADDR_W-1:0]             xl_addr;

  window_regs #(
    .DATA_W   (DATA_W),
    .NUM_WIN  (NUM_WIN),
    .MODE_LSB (MODE_LSB)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .win_lo  (win_lo),
    .win_hi  (win_hi),
    .mode    (mode)
  );

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_match
    window_match #(
      .HADDR_W (HADDR_W),
      .DATA_W  (DATA_W),
      .PFX_W   (PFX_W),
      .SEG_W   (SEG_W),
      .RNG_W   (RNG_W)
    ) u_match (
      .addr (req_addr),
      .lo   (win_lo[k]),
      .hi   (win_hi[k]),
      .hit  (w_hit[k])
    );
  end

  // Lowest-numbered hitting window wins.
  always_comb begin
    sel_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (w_hit[i]) sel_idx = IDX_W'(i);
    end
  end

  assign any_hit = |w_hit;
  assign bcast   = (mode == FWD_BCAST);
  assign pass    = any_hit && ((mode == FWD_PASS) || (bcast && req_short_wr));

  addr_xlate #(
    .HADDR_W (HADDR_W),
    .DADDR_W (DADDR_W),
    .PFX_W   (PFX_W),
    .SEG_W   (SEG_W),
    .TOP_W   (TOP_W),
    .BCAST_W (BCAST_W)
  ) u_xlate (
    .addr  (req_addr),
    .bcast (bcast),
    .daddr (xl_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_fwd   <= 1'b0;
      out_hit   <= 1'b0;
      out_win   <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid;
      out_fwd   <= req_valid && pass;
      out_hit   <= req_valid && any_hit;
      out_win   <= req_valid ? sel_idx : '0;
      out_addr  <= (req_valid && pass) ? xl_addr : '0;
    end
  end

  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(req_valid));

  // R1
  prefix_gate_chk: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> (&$past(req_addr[HADDR_W-1 -: PFX_W])));

  // R5
  dn_frame_chk: assert property (@(posedge clk) disable iff (rst)
    out_fwd |-> ((&out_addr[DADDR_W-1 -: TOP_W]) && out_addr[1:0] == 2'b00));

  // R6
  block_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mode) != FWD_PASS && $past(mode) != FWD_BCAST) |-> !out_fwd);

  // R7
  bcast_short_chk: assert property (@(posedge clk) disable iff (rst)
    (out_fwd && $past(mode) == FWD_BCAST) |->
      ($past(req_short_wr) && (&out_addr[DADDR_W-1 -: BCAST_W])));

  // R4
  win0_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(w_hit[0])) |-> (out_hit && out_win == '0));

endmodule

// File: tb/tb_io_window_fwd.sv
module tb_io_window_fwd;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        req_valid;
  logic [39:0] req_addr;
  logic        req_short_wr;
  logic        out_valid;
  logic        out_fwd;
  logic        out_hit;
  logic        out_win;
  logic [31:0] out_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_lo [2];
  logic [31:0] m_hi [2];
  logic [1:0]  m_mode;

  always #10 clk = ~clk;

  io_window_fwd dut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .req_valid (req_valid), .req_addr (req_addr), .req_short_wr (req_short_wr),
    .out_valid (out_valid), .out_fwd (out_fwd), .out_hit (out_hit),
    .out_win (out_win), .out_addr (out_addr)
  );

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected {valid, fwd, hit, win, addr} from the requirements.
  function automatic logic [34:0] model(input logic [39:0] a, input logic sw);
    logic [1:0]  h;
    logic        fwd;
    logic [31:0] da;
    for (int k = 0; k < 2; k++)
      h[k] = (a[39:32] == 8'hFF) && (a[31:28] == m_lo[k][15:12]) &&
             (a[27:16] >= m_lo[k][11:0]) && (a[27:16] < m_hi[k][11:0]);
    fwd = (h != 2'b00) && (m_mode == 2'd1 || (m_mode == 2'd3 && sw));
    da  = {4'hF, a[27:2], 2'b00};
    if (m_mode == 2'd3) da = da | 32'hFFFC_0000;
    return {1'b1, fwd, h != 2'b00, !h[0] && h[1], fwd ? da : 32'h0};
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      3'd0: m_mode = d[8:7];
      3'd1: m_lo[0] = d;
      3'd2: m_hi[0] = d;
      3'd3: m_lo[1] = d;
      3'd4: m_hi[1] = d;
      default: ;
    endcase
  endtask

  task automatic req(input string tag, input logic [39:0] a, input logic sw);
    logic [34:0] e;
    e = model(a, sw);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_short_wr = sw;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {out_valid, out_fwd, out_hit, out_win, out_addr}, e);
  endtask

  function automatic logic [39:0] mk(input logic [7:0] p, input logic [3:0] s,
                                     input logic [11:0] r, input logic [15:0] l);
    return {p, s, r, l};
  endfunction

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    req_valid = 1'b0; req_addr = '0; req_short_wr = 1'b0;
    m_lo[0] = '0; m_lo[1] = '0; m_hi[0] = '0; m_hi[1] = '0; m_mode = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 reset", {out_valid, out_fwd, out_hit, out_win, out_addr}, 35'h0);
    // R9 empty windows after reset: nothing hits
    req("R9 reset windows empty", mk(8'hFF, 4'h0, 12'h000, 16'h0), 1'b0);
    @(negedge clk);
    check("R9 no request, no valid", {32'h0, out_valid, out_fwd, out_hit}, 35'h0);

    // Overlapping windows, same segment 3 (R8 select encoding)
    wr(3'd1, 32'h0000_3010);
    wr(3'd2, 32'h0000_0020);
    wr(3'd3, 32'h0000_3018);
    wr(3'd4, 32'h0000_0030);

    // Sweep: R1 R2 R3 R4 R5 R6 R7 over every mode
    for (int m = 0; m < 4; m++) begin
      wr(3'd0, (32'hA5A5_A5A5 & ~32'h180) | (32'(m) << 7));
      for (int r = 0; r < 64; r++) begin
        for (int v = 0; v < 8; v++) begin
          logic [7:0] p;
          logic [3:0] s;
          p = v[0] ? 8'hFF : (v[1] ? 8'h7F : 8'hFE);
          s = v[1] ? 4'h3 : 4'h2;
          req($sformatf("R1 R2 R3 R4 R5 R6 R7 mode %0d r %0h v %0d", m, r, v),
              mk(p, s, 12'(r), 16'(r * 16'h9E37 + v)), v[2]);
        end
      end
    end

    wr(3'd0, 32'h0000_0080); // include mode
    // R3 ignored low bits: same span value, extreme low halves
    req("R3 low bits zero", mk(8'hFF, 4'h3, 12'h012, 16'h0000), 1'b0);
    req("R3 low bits ones", mk(8'hFF, 4'h3, 12'h012, 16'hFFFF), 1'b0);

    // R2 / R4: distinct segments per window
    wr(3'd3, 32'h0000_5018);
    req("R4 only window1 by segment", mk(8'hFF, 4'h5, 12'h01A, 16'h1234), 1'b0);
    req("R4 only window0 by segment", mk(8'hFF, 4'h3, 12'h01A, 16'h1234), 1'b0);
    req("R2 seg matches neither", mk(8'hFF, 4'h4, 12'h01A, 16'h1234), 1'b0);

    // R3 empty windows: low == high and low > high
    wr(3'd3, 32'h0000_3018);
    wr(3'd2, 32'h0000_0010);
    req("R3 window0 low==high empty", mk(8'hFF, 4'h3, 12'h010, 16'h0), 1'b0);
    req("R3 window1 still live", mk(8'hFF, 4'h3, 12'h01C, 16'h0), 1'b0);
    wr(3'd4, 32'h0000_0008);
    req("R3 window1 low>high empty", mk(8'hFF, 4'h3, 12'h018, 16'h0), 1'b0);
    req("R3 window1 low>high below", mk(8'hFF, 4'h3, 12'h00C, 16'h0), 1'b0);

    // R8 write timing: same-cycle request sees old high0, next sees new
    wr(3'd2, 32'h0000_0020);
    begin
      logic [34:0] e_old;
      logic [39:0] a;
      a = mk(8'hFF, 4'h3, 12'h030, 16'h0);
      e_old = model(a, 1'b0);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'h0000_0040;
      req_valid = 1'b1; req_addr = a; req_short_wr = 1'b0;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      m_hi[0] = 32'h0000_0040;
      check("R8 same-cycle write uses old bounds",
            {out_valid, out_fwd, out_hit, out_win, out_addr}, e_old);
      req("R8 next request uses new bounds", a, 1'b0);
    end

    // R6 reserved mode and bits outside [8:7]
    wr(3'd0, 32'hFFFF_FE7F); // mode 0, all other bits set
    req("R6 other ctrl bits set, mode 0", mk(8'hFF, 4'h3, 12'h015, 16'h0), 1'b1);
    wr(3'd0, 32'h0000_0100); // mode 2
    req("R6 reserved mode blocks", mk(8'hFF, 4'h3, 12'h015, 16'h0), 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule